// File: doc/BRIEF.md
# Segmented DAC switch decoder

This block sits in front of a segmented current-steering digital-to-analog converter. On each rising clock edge it captures a 10-bit sample word. It then splits the word into two fields. The upper five bits become 31 equal-weight thermometer segment enables. The lower five bits pass straight through as binary-weighted enables. Every enable drives a pair of steering controls: an A-side control and its complementary B-side control. The unit weights sent to the two sides therefore always add up to 1023.

The path has two registered stages. The first stage holds the captured word and the second holds the decoded switch controls, so a word captured at one edge reaches the outputs after the following edge. A new word is accepted on every clock and the converter cannot apply back-pressure, so the sample port has no valid or ready handshake. An active-high sleep input freezes both stages and forces every control inactive. A synchronous active-high reset clears both stages to code 0, which steers all current to the B side. A debug output rebuilds the code from the registered controls so that the decode can be checked.

Top module: `dac_seg_decoder`

## Requirements
- R1: The sample word is captured only on the rising clock edge. A word captured at edge k shows at the controls after edge k+1. A change on `sample_in` between edges has no effect on the outputs.
- R2: When awake, `seg_a[i]` is 1 exactly when i is less than the upper five bits of the registered code. Segments therefore fill from index 0 upward, and the count of active segments equals that field.
- R3: When awake, `lsb_a[i]` equals bit i of the registered code, with weight 2^i units. Each segment weighs 32 units.
- R4: When awake, each B-side control is the complement of its A-side control. The weights steered to the two sides sum to 1023.
- R5: On a step from code 31 to code 32, all five LSB enables turn off in the same output cycle that `seg_a[0]` turns on.
- R6: Code 1023 drives every A-side control to 1 and every B-side control to 0. Code 0 does the reverse. Code 512 turns on exactly 16 A-side segments.
- R7: While `sleep` is 1, all A-side and all B-side controls are 0, and both stages keep their contents whatever `sample_in` does.
- R8: After `sleep` returns to 0, the next edge moves the word held before sleep to the outputs and captures a new word. That new word appears one edge later.
- R9: A synchronous reset leaves registered code 0: `seg_a` and `lsb_a` all 0, `seg_b` and `lsb_b` all 1, and `code_rebuilt` 0.
- R10: `code_rebuilt` equals 32 times the number of active registered segments plus the registered LSB field. This is the word captured two edges earlier.
- R11: For a rising sequence of codes, no A-side segment that was on turns off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge captures and advances |
| rst | input | 1 | Synchronous active-high reset to code 0 |
| sleep | input | 1 | Active-high idle: freeze stages, all controls inactive |
| sample_in | input | 10 | Sample word, unsigned straight binary |
| seg_a | output | 31 | A-side thermometer segment controls |
| seg_b | output | 31 | B-side thermometer segment controls |
| lsb_a | output | 5 | A-side binary-weighted controls |
| lsb_b | output | 5 | B-side binary-weighted controls |
| code_rebuilt | output | 10 | Code rebuilt from the registered controls |

## Verification
A word presented before edge k is due on the controls and on `code_rebuilt` after edge k+1. Sleep and its release act on the controls in the same cycle, because the gating follows the registers. Reset shows after the edge that samples it. The bench keeps its own two-deep model of the pipeline, which advances only on edges where sleep is low. It drives inputs just after a falling edge and compares every output at the next falling edge. The rising-edge-only rule is checked by changing `sample_in` in mid-cycle and sampling again before the next rising edge.

// File: rtl/dac_seg_pkg.sv
package dac_seg_pkg;
  // Default word split: upper field thermometer coded, lower field binary
  localparam int DATA_W_DEF = 10;
  localparam int LSB_W_DEF  = 5;

  // Number of equal-weight segments produced from an msb_w-bit field
  function automatic int seg_count(input int msb_w);
    return (1 << msb_w) - 1;
  endfunction
endpackage

// File: rtl/dac_therm_decoder.sv
module dac_therm_decoder #(
  parameter int MSB_W = 5,
  localparam int SEG_N = (1 << MSB_W) - 1
) (
  input  logic [MSB_W-1:0] code_i,
  output logic [SEG_N-1:0] therm_o
);
  // Segment i is on when the field value exceeds i: fills from index 0 up
  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    assign therm_o[i] = (int'(code_i) > i);
  end
endmodule

// File: rtl/dac_code_rebuild.sv
module dac_code_rebuild #(
  parameter int MSB_W = 5,
  parameter int LSB_W = 5,
  localparam int SEG_N = (1 << MSB_W) - 1,
  localparam int DATA_W = MSB_W + LSB_W
) (
  input  logic [SEG_N-1:0]  seg_i,
  input  logic [LSB_W-1:0]  lsb_i,
  output logic [DATA_W-1:0] code_o
);
  logic [MSB_W-1:0] cnt;

  // Count active segments; each one weighs 2^LSB_W units
  always_comb begin
    cnt = '0;
    for (int i = 0; i < SEG_N; i++) begin
      cnt = cnt + {{(MSB_W-1){1'b0}}, seg_i[i]};
    end
    code_o = {cnt, lsb_i};
  end
endmodule

// File: rtl/dac_seg_decoder.sv
module dac_seg_decoder #(
  parameter int DATA_W = dac_seg_pkg::DATA_W_DEF,
  parameter int LSB_W  = dac_seg_pkg::LSB_W_DEF,
  localparam int MSB_W = DATA_W - LSB_W,
  localparam int SEG_N = dac_seg_pkg::seg_count(DATA_W - LSB_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic [DATA_W-1:0] sample_in,
  output logic [SEG_N-1:0]  seg_a,
  output logic [SEG_N-1:0]  seg_b,
  output logic [LSB_W-1:0]  lsb_a,
  output logic [LSB_W-1:0]  lsb_b,
  output logic [DATA_W-1:0] code_rebuilt
);
  logic [DATA_W-1:0] word_q;
  logic [SEG_N-1:0]  seg_d;
  logic [SEG_N-1:0]  seg_q;
  logic [LSB_W-1:0]  lsb_q;

  // Stage 1: input capture, frozen while asleep
  always_ff @(posedge clk) begin
    if (rst)        word_q <= '0;
    else if (!sleep) word_q <= sample_in;
  end

  dac_therm_decoder #(.MSB_W(MSB_W)) therm_i (
    .code_i  (word_q[DATA_W-1:LSB_W]),
    .therm_o (seg_d)
  );

  // Stage 2: decoded switch controls, frozen while asleep
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= '0;
      lsb_q <= '0;
    end else if (!sleep) begin
      seg_q <= seg_d;
      lsb_q <= word_q[LSB_W-1:0];
    end
  end

  // Complementary steering pairs, both sides idle in sleep
  always_comb begin
    seg_a = sleep ? '0 : seg_q;
    seg_b = sleep ? '0 : ~seg_q;
    lsb_a = sleep ? '0 : lsb_q;
    lsb_b = sleep ? '0 : ~lsb_q;
  end

  dac_code_rebuild #(.MSB_W(MSB_W), .LSB_W(LSB_W)) rebuild_i (
    .seg_i  (seg_q),
    .lsb_i  (lsb_q),
    .code_o (code_rebuilt)
  );

  // R2: registered segments always form a contiguous run from index 0
  a_r2_therm_shape: assert property (@(posedge clk) disable iff (rst)
    ((seg_q & (seg_q + SEG_N'(1))) == '0));

  // R4: awake pairs are complementary
  a_r4_complement: assert property (@(posedge clk) disable iff (rst)
    !sleep |-> ((&(seg_a ^ seg_b)) && (&(lsb_a ^ lsb_b))));

  // R7: every control idle during sleep
  a_r7_sleep_idle: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (!(|seg_a) && !(|seg_b) && !(|lsb_a) && !(|lsb_b)));

  // R7: both stages hold across a sleeping edge
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(word_q) && $stable(seg_q) && $stable(lsb_q)));

  // R1: stage 2 takes the low field that stage 1 held one edge earlier
  a_r1_stage_step: assert property (@(posedge clk) disable iff (rst)
    !sleep |=> (lsb_q == $past(word_q[LSB_W-1:0])));

  // R10: rebuilt upper field matches the active segment count
  a_r10_rebuild: assert property (@(posedge clk) disable iff (rst)
    (code_rebuilt[DATA_W-1:LSB_W] == MSB_W'($countones(seg_q))));
endmodule

// File: tb/dac_seg_decoder_tb.sv
`timescale 1ns/1ps
module dac_seg_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        sleep;
  logic [9:0]  sample_in;
  logic [30:0] seg_a, seg_b;
  logic [4:0]  lsb_a, lsb_b;
  logic [9:0]  code_rebuilt;

  int n_tests = 0;
  int n_fail  = 0;
  int q1 = 0, q2 = 0;     // bench pipeline model
  logic [30:0] prev_seg;

  always #4 clk = ~clk;   // 125 MHz

  dac_seg_decoder dut_i (
    .clk(clk), .rst(rst), .sleep(sleep), .sample_in(sample_in),
    .seg_a(seg_a), .seg_b(seg_b), .lsb_a(lsb_a), .lsb_b(lsb_b),
    .code_rebuilt(code_rebuilt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [30:0] therm(input int code);
    logic [30:0] e = '0;
    for (int i = 0; i < 31; i++) if (i < (code >> 5)) e[i] = 1'b1;
    return e;
  endfunction

  // Compare every output against the model
  task automatic check_all();
    logic [30:0] e = therm(q2);
    if (sleep) begin
      chk(seg_a == 0 && seg_b == 0, "R7", "seg idle", {seg_a[15:0], seg_b[15:0]}, 0);
      chk(lsb_a == 0 && lsb_b == 0, "R7", "lsb idle", {lsb_a, lsb_b}, 0);
    end else begin
      chk(seg_a == e, "R2", "seg_a", int'(seg_a), int'(e));
      chk(seg_b == ~e, "R4", "seg_b", int'(seg_b), int'(~e));
      chk(lsb_a == q2[4:0], "R3", "lsb_a", int'(lsb_a), q2 & 31);
      chk(lsb_b == ~q2[4:0], "R4", "lsb_b", int'(lsb_b), ~q2 & 31);
    end
    chk(code_rebuilt == q2[9:0], "R10", "code_rebuilt", int'(code_rebuilt), q2);
  endtask

  // Drive inputs, pass one rising edge, update the model, check at falling edge
  task automatic step(input int code, input bit slp, input bit r);
    sample_in = code[9:0];
    sleep = slp;
    rst = r;
    @(posedge clk);
    if (r) begin q1 = 0; q2 = 0; end
    else if (!slp) begin q2 = q1; q1 = code; end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; sleep = 1'b0; sample_in = 10'h3ff;
    step(1023, 0, 1);
    step(1023, 0, 1);
    // R9: reset state
    chk(seg_a == 0 && lsb_a == 0, "R9", "A side cleared", {seg_a[26:0], lsb_a}, 0);
    chk(&seg_b && &lsb_b, "R9", "B side full", {seg_b[26:0], lsb_b}, 32'hffffffff);
    chk(code_rebuilt == 0, "R9", "rebuilt zero", int'(code_rebuilt), 0);

    // R1: latency of two edges
    step(77, 0, 0);
    chk(code_rebuilt == 0, "R1", "not yet visible", int'(code_rebuilt), 0);
    step(5, 0, 0);
    chk(code_rebuilt == 77, "R1", "visible after second edge", int'(code_rebuilt), 77);
    // R1: mid-cycle change of the input has no effect
    sample_in = 10'h2aa;
    #2;
    chk(code_rebuilt == 77, "R1", "mid-cycle change ignored", int'(code_rebuilt), 77);

    // Exhaustive ascending sweep, with monotonic and carry checks
    step(0, 0, 0);
    step(0, 0, 0);
    prev_seg = seg_a;
    for (int c = 1; c < 1024 + 2; c++) begin
      step(c < 1024 ? c : 1023, 0, 0);
      chk((prev_seg & ~seg_a) == 0, "R11", "segment dropped", int'(seg_a), int'(prev_seg));
      if (q2 == 32 && code_rebuilt == 32) begin
        chk(lsb_a == 0 && seg_a == 31'd1, "R5", "carry 31->32",
            {seg_a[26:0], lsb_a}, 32);
        chk(prev_seg == 0, "R5", "no segment before carry", int'(prev_seg), 0);
      end
      prev_seg = seg_a;
    end

    // R6: end points and mid-scale
    step(1023, 0, 0); step(0, 0, 0);
    chk(&seg_a && &lsb_a && seg_b == 0 && lsb_b == 0, "R6", "full scale",
        int'(seg_a), 32'h7fffffff);
    step(512, 0, 0);
    chk(seg_a == 0 && lsb_a == 0 && &seg_b && &lsb_b, "R6", "zero scale",
        int'(seg_b), 32'h7fffffff);
    step(512, 0, 0);
    chk($countones(seg_a) == 16, "R6", "mid-scale segments", $countones(seg_a), 16);
    chk(int'(code_rebuilt) + int'(1023 - code_rebuilt) == 1023 &&
        $countones(seg_b) == 15, "R4", "B side segments at mid", $countones(seg_b), 15);

    // R7/R8: sleep holds, then resumes
    step(100, 0, 0);
    step(200, 0, 0);
    step(300, 1, 0);
    step(400, 1, 0);
    chk(code_rebuilt == 100, "R7", "stages held", int'(code_rebuilt), 100);
    step(500, 0, 0);
    chk(code_rebuilt == 200, "R8", "held word first", int'(code_rebuilt), 200);
    step(600, 0, 0);
    chk(code_rebuilt == 500, "R8", "new word next", int'(code_rebuilt), 500);

    // Random sequences with sporadic sleep and one reset
    for (int k = 0; k < 600; k++) begin
      step(int'($urandom_range(1023)), ($urandom_range(7) == 0), (k == 300));
    end
    step(3, 0, 0);
    step(3, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule